// File: doc/BRIEF.md
# Overflow-Triggered Event Sampling Unit

This block counts pulses of one selected event in a wide up-counter. When the counter rolls over past its all-ones value, the unit takes a snapshot of the instruction pointer, the flags word and a small set of general-purpose register values. It stores that snapshot as one fixed-size record in a bounded linear buffer in memory. It then reloads the counter from a programmable value and counts on. Loading the reload value with the two's complement of N gives one record every N events.

Software sets the unit up through a small register port: the buffer base, the current write index, an absolute limit, an interrupt threshold, the reload value, the live count and an enable bit. Records go out as a stream of 64-bit words on a synchronous memory write port, one word per clock. The buffer never wraps. Once a record no longer fits below the limit, further samples are discarded. A level interrupt tells software when the index has crossed the threshold, so that it can drain the records and rewind the index.

Top module: `evsamp_top`

## Requirements
- R1: While enabled, each clock with `event_in` high adds one to the counter (register address 7, readable and writable, 16 bits wide).
- R2: An event arriving while the counter holds all ones is an overflow. The counter takes the reload value (address 5), so a reload value of 2^16-N yields exactly one overflow every N events.
- R3: An accepted overflow produces REC_WORDS = 2+NUM_GPR consecutive cycles with `mem_we` high, starting the cycle after the overflow edge. Word k goes to index+8k. Word 0 is `ip_in`, word 1 is `flags_in`, and word 2+j is `gpr_in[64j+:64]`, all sampled at the overflow edge.
- R4: After the last word of a record, the index (address 2) grows by REC_BYTES = 8*REC_WORDS.
- R5: A record is started only when index+REC_BYTES is no greater than the limit (address 3). Otherwise the sample is dropped, the index is left unchanged and never wraps.
- R6: `irq` rises when an index advance leaves the index at or above the threshold (address 4). It stays high until software writes address 6 with bit 0 set.
- R7: An overflow during a record write is held in one pending slot with its own snapshot. That record is written right after the current one. Overflows while the slot is full increment a saturating 8-bit dropped counter, read at address 6 bits 8:1 and cleared by writing address 6 with bit 1 set.
- R8: Events during a record write keep counting from the reloaded value.
- R9: With the enable (address 0 bit 0) low, events change neither the counter nor the buffer, while configuration writes still take effect.
- R10: Register map: 0 control, 1 base, 2 index, 3 limit, 4 threshold, 5 reload, 6 status (read bit 0 = irq), 7 counter. `cfg_rdata` returns the register selected by `cfg_addr` one clock later. Writing address 6 with bit 2 set sets the index to the base.
- R11: After reset, all registers, `irq` and `mem_we` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| event_in | input | 1 | Qualified event pulse, one count per cycle high |
| ip_in | input | 64 | Current instruction pointer |
| flags_in | input | 64 | Current flags word |
| gpr_in | input | NUM_GPR*64 | Current general-purpose register values |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Registered read data |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | ADDR_W | Buffer byte address |
| mem_wdata | output | 64 | Buffer write data |
| irq | output | 1 | Threshold interrupt, level |

## Verification
The bench drives bursts in which every event overflows. The pending slot fills, is replaced on the last word of a record, and overflows then land while the slot is still full. A design that serviced the slot late, lost its snapshot or counted drops at the wrong time would emit wrong words or report a wrong dropped count. The buffer is filled to exactly the limit, and one more sample is then attempted. A design with an off-by-one in the fit check would either lose the last record or write past the limit. Counts are made across a record write and with the enable low. A design that froze the counter while busy, or that counted while disabled, would read back a wrong count. The interrupt is checked just below and at the threshold and after a clear, which exposes an edge-triggered or self-clearing interrupt.

// File: rtl/evsamp_pkg.sv
package evsamp_pkg;
  typedef enum logic {WS_IDLE, WS_BUSY} wstate_t;

  // register map (R10)
  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_BASE   = 3'd1;
  localparam logic [2:0] RA_INDEX  = 3'd2;
  localparam logic [2:0] RA_LIMIT  = 3'd3;
  localparam logic [2:0] RA_THRESH = 3'd4;
  localparam logic [2:0] RA_RELOAD = 3'd5;
  localparam logic [2:0] RA_STATUS = 3'd6;
  localparam logic [2:0] RA_COUNT  = 3'd7;

  localparam int WORD_SHIFT = 3;  // 8 bytes per record word
endpackage

// File: rtl/evsamp_cfg.sv
module evsamp_cfg
  import evsamp_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic              en,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] limit,
  output logic [ADDR_W-1:0] thresh,
  output logic [CNT_W-1:0]  reload,
  output logic              idx_wr,
  output logic              cnt_wr,
  output logic              clr_irq,
  output logic              clr_drop,
  output logic              rewind
);
  logic stat_wr;

  assign idx_wr   = cfg_we && (cfg_addr == RA_INDEX);
  assign cnt_wr   = cfg_we && (cfg_addr == RA_COUNT);
  assign stat_wr  = cfg_we && (cfg_addr == RA_STATUS);
  assign clr_irq  = stat_wr && cfg_wdata[0];
  assign clr_drop = stat_wr && cfg_wdata[1];
  assign rewind   = stat_wr && cfg_wdata[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      base   <= '0;
      limit  <= '0;
      thresh <= '0;
      reload <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        RA_CTRL:   en     <= cfg_wdata[0];
        RA_BASE:   base   <= cfg_wdata[ADDR_W-1:0];
        RA_LIMIT:  limit  <= cfg_wdata[ADDR_W-1:0];
        RA_THRESH: thresh <= cfg_wdata[ADDR_W-1:0];
        RA_RELOAD: reload <= cfg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // R9: the enable follows a control write on the next clock
  p_enable_write_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == RA_CTRL) |=> (en == $past(cfg_wdata[0])));
endmodule

// File: rtl/evsamp_counter.sv
module evsamp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             event_in,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  assign ovf = en && event_in && !load && (cnt == '1);

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (en && event_in)  cnt <= ovf ? reload : cnt + 1'b1;
  end

  // R2: an overflow leaves the reload value in the counter
  p_reload_r2: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt == $past(reload)));
  // R9: no event counting while disabled
  p_hold_disabled_r9: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(cnt));
  // R1: a plain event adds one
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (en && event_in && !load && !ovf) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/evsamp_writer.sv
module evsamp_writer
  import evsamp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 64,
  parameter int NUM_GPR = 2,
  parameter int DROP_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ovf,
  input  logic [DATA_W-1:0]         ip_in,
  input  logic [DATA_W-1:0]         flags_in,
  input  logic [NUM_GPR*DATA_W-1:0] gpr_in,
  input  logic [ADDR_W-1:0]         base,
  input  logic [ADDR_W-1:0]         limit,
  input  logic [ADDR_W-1:0]         thresh,
  input  logic                      idx_wr,
  input  logic [ADDR_W-1:0]         idx_val,
  input  logic                      rewind,
  input  logic                      clr_irq,
  input  logic                      clr_drop,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  output logic [ADDR_W-1:0]         index,
  output logic                      irq,
  output logic [DROP_W-1:0]         drop_cnt
);
  localparam int REC_WORDS = 2 + NUM_GPR;
  localparam int REC_BYTES = REC_WORDS << WORD_SHIFT;
  localparam int WIDX_W    = $clog2(REC_WORDS);

  wstate_t           st;
  logic [WIDX_W-1:0] widx;
  logic              pend_v;
  logic [DATA_W-1:0] cur_w     [REC_WORDS];
  logic [DATA_W-1:0] snap      [REC_WORDS];
  logic [DATA_W-1:0] pend_snap [REC_WORDS];
  logic [ADDR_W-1:0] next_idx;
  logic [ADDR_W-1:0] word_off;
  logic [ADDR_W:0]   end_cur, end_next;
  logic              fits_cur, fits_next, last;

  // snapshot word order: pointer, flags, then registers
  for (genvar k = 0; k < REC_WORDS; k++) begin : g_word
    if (k == 0) begin : g_ip
      assign cur_w[k] = ip_in;
    end else if (k == 1) begin : g_fl
      assign cur_w[k] = flags_in;
    end else begin : g_gp
      assign cur_w[k] = gpr_in[(k-2)*DATA_W +: DATA_W];
    end
  end

  assign next_idx  = index + ADDR_W'(REC_BYTES);
  assign word_off  = ADDR_W'(widx) << WORD_SHIFT;
  assign end_cur   = {1'b0, index}    + (ADDR_W+1)'(REC_BYTES);
  assign end_next  = {1'b0, next_idx} + (ADDR_W+1)'(REC_BYTES);
  assign fits_cur  = end_cur  <= {1'b0, limit};
  assign fits_next = end_next <= {1'b0, limit};
  assign last      = (widx == WIDX_W'(REC_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= WS_IDLE;
      widx      <= '0;
      pend_v    <= 1'b0;
      index     <= '0;
      irq       <= 1'b0;
      drop_cnt  <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (clr_irq)  irq      <= 1'b0;
      if (clr_drop) drop_cnt <= '0;
      if (idx_wr)      index <= idx_val;
      else if (rewind) index <= base;
      case (st)
        WS_IDLE: begin
          if (ovf && fits_cur) begin
            snap <= cur_w;
            widx <= '0;
            st   <= WS_BUSY;
          end
        end
        WS_BUSY: begin
          mem_we    <= 1'b1;
          mem_addr  <= index + word_off;
          mem_wdata <= snap[widx];
          if (!last) begin
            widx <= widx + 1'b1;
            if (ovf) begin
              if (pend_v) begin
                if (drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
              end else begin
                pend_v    <= 1'b1;
                pend_snap <= cur_w;
              end
            end
          end else begin
            index <= next_idx;
            widx  <= '0;
            if (next_idx >= thresh) irq <= 1'b1;
            if (pend_v) begin
              if (fits_next) begin
                snap   <= pend_snap;
                pend_v <= ovf;
                if (ovf) pend_snap <= cur_w;
              end else begin
                pend_v <= 1'b0;
                st     <= WS_IDLE;
              end
            end else if (ovf && fits_next) begin
              snap <= cur_w;
            end else begin
              st <= WS_IDLE;
            end
          end
        end
        default: st <= WS_IDLE;
      endcase
    end
  end

  // R6: interrupt holds until cleared
  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_irq) |=> irq);
  // R7: dropped count moves only on an overflow against a full slot
  p_drop_only_pending_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr_drop && !(ovf && pend_v)) |=> $stable(drop_cnt));
  // R4: index changes only at a record end or a software write
  p_index_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!idx_wr && !rewind && !(st == WS_BUSY && last)) |=> $stable(index));
  // R5: no write at or above the limit
  p_in_limit_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ({1'b0, mem_addr} < {1'b0, limit}));
endmodule

// File: rtl/evsamp_top.sv
module evsamp_top
  import evsamp_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 16,
  parameter int REG_W   = 16,
  parameter int DATA_W  = 64,
  parameter int NUM_GPR = 2,
  parameter int DROP_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      event_in,
  input  logic [DATA_W-1:0]         ip_in,
  input  logic [DATA_W-1:0]         flags_in,
  input  logic [NUM_GPR*DATA_W-1:0] gpr_in,
  input  logic                      cfg_we,
  input  logic [2:0]                cfg_addr,
  input  logic [REG_W-1:0]          cfg_wdata,
  output logic [REG_W-1:0]          cfg_rdata,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  output logic                      irq
);
  logic              en, idx_wr, cnt_wr, clr_irq, clr_drop, rewind, ovf;
  logic [ADDR_W-1:0] base, limit, thresh, index;
  logic [CNT_W-1:0]  reload, cnt;
  logic [DROP_W-1:0] drop_cnt;

  evsamp_cfg #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .en(en), .base(base), .limit(limit),
    .thresh(thresh), .reload(reload), .idx_wr(idx_wr), .cnt_wr(cnt_wr),
    .clr_irq(clr_irq), .clr_drop(clr_drop), .rewind(rewind)
  );

  evsamp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .event_in(event_in), .load(cnt_wr),
    .load_val(cfg_wdata[CNT_W-1:0]), .reload(reload), .cnt(cnt), .ovf(ovf)
  );

  evsamp_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_GPR(NUM_GPR),
                  .DROP_W(DROP_W)) u_wr (
    .clk(clk), .rst(rst), .ovf(ovf), .ip_in(ip_in), .flags_in(flags_in),
    .gpr_in(gpr_in), .base(base), .limit(limit), .thresh(thresh),
    .idx_wr(idx_wr), .idx_val(cfg_wdata[ADDR_W-1:0]), .rewind(rewind),
    .clr_irq(clr_irq), .clr_drop(clr_drop), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .index(index), .irq(irq),
    .drop_cnt(drop_cnt)
  );

  // registered read port, one clock of latency (R10)
  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else begin
      case (cfg_addr)
        RA_CTRL:   cfg_rdata <= REG_W'(en);
        RA_BASE:   cfg_rdata <= REG_W'(base);
        RA_INDEX:  cfg_rdata <= REG_W'(index);
        RA_LIMIT:  cfg_rdata <= REG_W'(limit);
        RA_THRESH: cfg_rdata <= REG_W'(thresh);
        RA_RELOAD: cfg_rdata <= REG_W'(reload);
        RA_STATUS: cfg_rdata <= REG_W'({drop_cnt, irq});
        default:   cfg_rdata <= REG_W'(cnt);
      endcase
    end
  end
endmodule

// File: tb/sim_evsamp_top.sv
`timescale 1ns/1ps
module sim_evsamp_top;
  localparam int RW = 4;
  localparam int RB = 32;

  logic         clk = 0;
  logic         rst = 1;
  logic         event_in = 0;
  logic [63:0]  ip_in = 0, flags_in = 0;
  logic [127:0] gpr_in = 0;
  logic         cfg_we = 0;
  logic [2:0]   cfg_addr = 0;
  logic [15:0]  cfg_wdata = 0;
  logic [15:0]  cfg_rdata;
  logic         mem_we;
  logic [15:0]  mem_addr;
  logic [63:0]  mem_wdata;
  logic         irq;

  int checks = 0, errors = 0, words = 0, cyc = 0;

  evsamp_top u0 (.*);

  always #4 clk = ~clk;  // 125 MHz

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_cnt, m_base, m_idx, m_lim, m_thr, m_rel;
  bit          m_en, m_irq, m_pend;
  int          m_drop;
  logic [63:0] m_psnap [RW];
  logic [63:0] q_data[$];
  logic [15:0] q_addr[$];
  bit          e_we, e_irq;
  logic [15:0] e_addr, e_rd;
  logic [63:0] e_data;

  function automatic logic [63:0] in_word(int k);
    if (k == 0) return ip_in;
    if (k == 1) return flags_in;
    return gpr_in[(k-2)*64 +: 64];
  endfunction

  function automatic bit room(int idx);
    return (idx + RB) <= int'(m_lim);
  endfunction

  function automatic logic [15:0] model_read(logic [2:0] a);
    case (a)
      3'd0: return {15'd0, m_en};
      3'd1: return m_base;
      3'd2: return m_idx;
      3'd3: return m_lim;
      3'd4: return m_thr;
      3'd5: return m_rel;
      3'd6: return 16'((m_drop << 1) | int'(m_irq));
      default: return m_cnt;
    endcase
  endfunction

  task automatic push_live(logic [15:0] at);
    for (int k = 0; k < RW; k++) begin
      q_addr.push_back(at + 16'(8*k));
      q_data.push_back(in_word(k));
    end
  endtask

  task automatic push_pend(logic [15:0] at);
    for (int k = 0; k < RW; k++) begin
      q_addr.push_back(at + 16'(8*k));
      q_data.push_back(m_psnap[k]);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_base = 0; m_idx = 0; m_lim = 0; m_thr = 0; m_rel = 0;
      m_en = 0; m_irq = 0; m_pend = 0; m_drop = 0;
      q_data.delete(); q_addr.delete();
      e_we = 0; e_irq = 0; e_addr = 0; e_data = 0; e_rd = 0;
    end else begin
      bit ov, wr_cnt;
      e_rd   = model_read(cfg_addr);
      wr_cnt = cfg_we && cfg_addr == 3'd7;
      ov     = m_en && event_in && !wr_cnt && m_cnt == 16'hFFFF;
      if (cfg_we && cfg_addr == 3'd6 && cfg_wdata[0]) m_irq = 0;
      if (cfg_we && cfg_addr == 3'd6 && cfg_wdata[1]) m_drop = 0;
      if (q_data.size() > 0) begin
        e_we = 1; e_addr = q_addr.pop_front(); e_data = q_data.pop_front();
        if (q_data.size() != 0) begin
          if (ov) begin
            if (m_pend) begin
              if (m_drop < 255) m_drop++;
            end else begin
              m_pend = 1;
              for (int k = 0; k < RW; k++) m_psnap[k] = in_word(k);
            end
          end
        end else begin
          m_idx = m_idx + 16'(RB);
          if (m_idx >= m_thr) m_irq = 1;
          if (m_pend) begin
            if (room(int'(m_idx))) begin
              push_pend(m_idx);
              m_pend = ov;
              if (ov) for (int k = 0; k < RW; k++) m_psnap[k] = in_word(k);
            end else m_pend = 0;
          end else if (ov && room(int'(m_idx))) push_live(m_idx);
        end
      end else begin
        e_we = 0;
        if (ov && room(int'(m_idx))) push_live(m_idx);
      end
      if (wr_cnt) m_cnt = cfg_wdata;
      else if (m_en && event_in) m_cnt = ov ? m_rel : m_cnt + 16'd1;
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: m_en = cfg_wdata[0];
          3'd1: m_base = cfg_wdata;
          3'd2: m_idx = cfg_wdata;
          3'd3: m_lim = cfg_wdata;
          3'd4: m_thr = cfg_wdata;
          3'd5: m_rel = cfg_wdata;
          3'd6: if (cfg_wdata[2]) m_idx = m_base;
          default: ;
        endcase
      end
      e_irq = m_irq;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    ip_in    <= {32'hA5A5_0000, 32'(cyc)};
    flags_in <= 64'(cyc * 7 + 3);
    gpr_in   <= {64'(cyc ^ 32'h5555), 64'hC0DE_0000_0000_0000 | 64'(cyc)};
    if (!rst) begin
      if (mem_we) words++;
      checks++;
      if (mem_we !== e_we || (e_we && (mem_addr !== e_addr || mem_wdata !== e_data))) begin
        errors++;
        $display("FAIL R3 record port we/addr/data act=%0b/%0h/%0h exp=%0b/%0h/%0h",
                 mem_we, mem_addr, mem_wdata, e_we, e_addr, e_data);
      end
      checks++;
      if (irq !== e_irq) begin
        errors++;
        $display("FAIL R6 irq act=%0b exp=%0b", irq, e_irq);
      end
      checks++;
      if (cfg_rdata !== e_rd) begin
        errors++;
        $display("FAIL R10 rdata act=%0h exp=%0h", cfg_rdata, e_rd);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0; cfg_addr = 3'd7;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); #1 v = cfg_rdata;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); event_in = 1;
      @(negedge clk); event_in = 0;
      repeat (2) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic burst(int n);
    @(negedge clk); event_in = 1;
    repeat (n) @(negedge clk);
    event_in = 0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq", 32'(irq), 0);
    chk("R11 mem_we", 32'(mem_we), 0);
    rd(3'd2, v); chk("R11 index", 32'(v), 0);
    rd(3'd7, v); chk("R11 counter", 32'(v), 0);

    wr(3'd5, 16'hFFFD); wr(3'd7, 16'hFFFD);
    wr(3'd1, 16'h0100); wr(3'd2, 16'h0100);
    wr(3'd3, 16'h0180); wr(3'd4, 16'h0160);
    // R9 disabled events ignored
    pulses(5);
    rd(3'd7, v); chk("R9 counter while disabled", 32'(v), 32'hFFFD);
    chk("R9 no record while disabled", 32'(words), 0);

    wr(3'd0, 16'h0001);
    pulses(2);
    rd(3'd7, v); chk("R1 counter after two events", 32'(v), 32'hFFFF);
    chk("R2 no record before N events", 32'(words), 0);
    pulses(1);
    chk("R2 one record after N events", 32'(words), RW);
    rd(3'd7, v); chk("R2 reloaded", 32'(v), 32'hFFFD);
    rd(3'd2, v); chk("R4 index after one record", 32'(v), 32'h0120);
    pulses(3);
    rd(3'd2, v); chk("R4 index after two records", 32'(v), 32'h0140);
    chk("R6 irq below threshold", 32'(irq), 0);
    pulses(3);
    chk("R6 irq at threshold", 32'(irq), 1);
    pulses(3);
    rd(3'd2, v); chk("R5 last record fits exactly", 32'(v), 32'h0180);
    pulses(3);
    rd(3'd2, v); chk("R5 index kept when full", 32'(v), 32'h0180);
    chk("R5 no write when full", 32'(words), 4*RW);
    chk("R6 irq still high", 32'(irq), 1);
    wr(3'd6, 16'h0001);
    @(negedge clk);
    chk("R6 irq cleared", 32'(irq), 0);
    wr(3'd6, 16'h0004);
    rd(3'd2, v); chk("R10 rewind to base", 32'(v), 32'h0100);

    // R7 back-to-back overflows
    wr(3'd3, 16'h0300); wr(3'd5, 16'hFFFF); wr(3'd7, 16'hFFFF);
    burst(6);
    rd(3'd6, v); chk("R7 dropped count and irq", 32'(v), 32'h0007);
    rd(3'd2, v); chk("R7 pending records written", 32'(v), 32'h0160);
    chk("R7 word total", 32'(words), 7*RW);
    wr(3'd6, 16'h0002);
    rd(3'd6, v); chk("R7 dropped cleared", 32'(v), 32'h0001);
    wr(3'd6, 16'h0001);

    // R8 counting during a record write
    wr(3'd5, 16'hFFFD); wr(3'd7, 16'hFFFF);
    burst(4);
    rd(3'd7, v); chk("R8 counter after busy events", 32'(v), 32'hFFFD);
    rd(3'd2, v); chk("R8 index after two records", 32'(v), 32'h01A0);
    chk("R8 word total", 32'(words), 9*RW);

    // R9 disable again
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0200);
    pulses(4);
    rd(3'd7, v); chk("R9 counter frozen", 32'(v), 32'hFFFD);
    rd(3'd2, v); chk("R9 index write while disabled", 32'(v), 32'h0200);
    chk("R9 no words while disabled", 32'(words), 9*RW);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule